// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block is the address arithmetic of a signal-processing datapath. It holds eight 24-bit pointer registers, two index registers and one block-length register. On each access cycle it reads the selected pointer and picks a displacement from one of four sources. It then produces the effective memory address and the value the pointer takes afterwards. Both results come out combinationally in the cycle of the access, and the pointer register is updated on the following clock edge.

Several addressing forms are supported. Plain indirect uses the pointer as it stands. Linear pre- and post-modify move the pointer by the displacement in either direction. Offset access adds the displacement without moving the pointer. Circular post-modify confines the pointer to a buffer whose base sits on a power-of-two boundary and whose length comes from the block-length register. Bit-reversed post-increment adds index register 0 with the carry running from the top bit downward, which produces the scrambled order of a radix-2 FFT.

Registers are loaded through a single write port. Instruction decode, the memory itself and pipeline interlocks lie outside the block.

Top module: `addr_gen_unit`

## Requirements
- R1: After a synchronous active-low reset, every pointer, both index registers and the block length read as zero.
- R2: The write port loads the register selected by `wr_addr` on the next clock edge: codes 0..7 select pointers 0..7, code 8 selects index 0, code 9 selects index 1 and code 10 selects the block length. Codes 11..15 change nothing. When the port writes the same pointer that an access updates in the same cycle, the written value wins.
- R3: `disp_src` selects the displacement: 0 selects `disp_imm` zero-extended (8-bit unsigned), 1 selects index 0, 2 selects index 1 and 3 selects the constant 1.
- R4: Mode 0 (plain) gives `ea` equal to the pointer, and the pointer keeps its value.
- R5: Modes 1 and 2 (post-increment and post-decrement) give `ea` equal to the old pointer. The pointer becomes pointer plus or minus the displacement, modulo 2^24.
- R6: Modes 3 and 4 (pre-increment and pre-decrement) give `ea` equal to pointer plus or minus the displacement, modulo 2^24, and that same value is written back to the pointer.
- R7: Mode 5 (offset) gives `ea` equal to pointer plus displacement, modulo 2^24, and the pointer keeps its value.
- R8: Modes 6 and 7 (circular increment and decrement) give `ea` equal to the old pointer. Let N be the smallest value with 2^N greater than the block length L. The base is the pointer with its low N bits cleared, and the offset is the low N bits. The new pointer is the base plus ((offset ± displacement) mod L), provided the offset is below L. For example, with L=4, pointer 0x809913 and a displacement of 1, the pointer returns to 0x809910.
- R9: A block length of 0 makes modes 6 and 7 behave like modes 1 and 2.
- R10: Mode 8 (bit-reversed) gives `ea` equal to the old pointer. The pointer becomes the sum of the pointer and index 0, with the carry propagating from bit 23 toward bit 0. `disp_src` plays no part in this mode.
- R11: `ptr_we` is high only when `acc_valid` is high and the mode updates the pointer (modes 1, 2, 3, 4, 6, 7 and 8). Modes 9..15 act as plain. `ptr_next` always shows the value the pointer would take, which is the unchanged pointer in modes that do not update it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access takes place this cycle |
| acc_mode | input | 4 | Addressing mode code |
| acc_sel | input | 3 | Pointer register used by the access |
| disp_src | input | 2 | Displacement source |
| disp_imm | input | 8 | Immediate displacement |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register written |
| wr_data | input | 24 | Value written |
| ea | output | 24 | Effective address of the access |
| ptr_next | output | 24 | Value the selected pointer takes |
| ptr_we | output | 1 | The selected pointer is updated at the next edge |

## Verification
On every cycle the assertions check how the register file resolves its two writers. A written value always lands, an access update lands when the write port is not aimed at the same pointer, and an untouched pointer stays still. They also check that a circular step started inside its buffer stays inside it, that pre-modify writes back its own address and that offset access never moves a pointer. Only the bench's scenarios can confirm the arithmetic results themselves. That covers the wrap positions for every start offset of several buffer lengths, and displacements larger than the buffer. It also covers the FFT reorder sequence produced by reverse-carry addition and the effect of ignored write codes, which the bench reads back through later accesses.

// File: rtl/agu_pkg.sv
// Shared encodings of the address generator.
// Assumes: mode codes are fixed by the surrounding decode; unlisted codes act as plain.
package agu_pkg;

    typedef enum logic [3:0] {
        AM_PLAIN    = 4'd0,
        AM_POST_INC = 4'd1,
        AM_POST_DEC = 4'd2,
        AM_PRE_INC  = 4'd3,
        AM_PRE_DEC  = 4'd4,
        AM_OFFSET   = 4'd5,
        AM_CIRC_INC = 4'd6,
        AM_CIRC_DEC = 4'd7,
        AM_BITREV   = 4'd8
    } agu_mode_e;

    typedef enum logic [1:0] {
        DS_IMM  = 2'd0,
        DS_IDX0 = 2'd1,
        DS_IDX1 = 2'd2,
        DS_UNIT = 2'd3
    } agu_disp_e;

endpackage

// File: rtl/agu_regfile.sv
// Pointer, index and block-length storage.
// Write-port map: 0..NPTR-1 pointers, NPTR index 0, NPTR+1 index 1,
// NPTR+2 block length; higher codes are ignored.
// Assumes: the write port has priority over an access update of the same pointer.
module agu_regfile #(
    parameter int ADDR_W = 24,
    parameter int NPTR   = 8,
    parameter int SEL_W  = 3,
    parameter int WA_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [WA_W-1:0]              wr_addr,
    input  logic [ADDR_W-1:0]            wr_data,
    input  logic                         upd_en,
    input  logic [SEL_W-1:0]             upd_sel,
    input  logic [ADDR_W-1:0]            upd_val,
    output logic [NPTR-1:0][ADDR_W-1:0]  ptr_q,
    output logic [ADDR_W-1:0]            idx0_q,
    output logic [ADDR_W-1:0]            idx1_q,
    output logic [ADDR_W-1:0]            blk_q
);

    localparam logic [WA_W-1:0] IDX0_A = WA_W'(NPTR);
    localparam logic [WA_W-1:0] IDX1_A = WA_W'(NPTR + 1);
    localparam logic [WA_W-1:0] BLK_A  = WA_W'(NPTR + 2);

    // Pointer registers: write port first, then the access update.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NPTR; k++) begin
            if (!rst_n) begin
                ptr_q[k] <= '0;
            end else if (wr_en && wr_addr == WA_W'(k)) begin
                ptr_q[k] <= wr_data;
            end else if (upd_en && upd_sel == SEL_W'(k)) begin
                ptr_q[k] <= upd_val;
            end
        end
    end

    // Index and block-length registers, loaded only through the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx0_q <= '0;
            idx1_q <= '0;
            blk_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == IDX0_A) idx0_q <= wr_data;
            if (wr_addr == IDX1_A) idx1_q <= wr_data;
            if (wr_addr == BLK_A)  blk_q  <= wr_data;
        end
    end

    for (genvar g = 0; g < NPTR; g++) begin : g_chk
        AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == WA_W'(g)) |=> (ptr_q[g] == $past(wr_data))); // R2

        AST_UPDATE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && upd_sel == SEL_W'(g) && !(wr_en && wr_addr == WA_W'(g)))
            |=> (ptr_q[g] == $past(upd_val))); // R11

        AST_UNTOUCHED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!(upd_en && upd_sel == SEL_W'(g)) && !(wr_en && wr_addr == WA_W'(g)))
            |=> $stable(ptr_q[g])); // R4
    end

endmodule

// File: rtl/agu_circ_step.sv
// Circular post-modify step.
// The buffer base is the pointer with the bits below the smallest power of two
// above LEN cleared; the offset moves modulo LEN in either direction.
// Assumes: the incoming offset is below LEN. LEN == 0 gives a linear step.
module agu_circ_step #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] disp,
    input  logic [ADDR_W-1:0] len,
    input  logic              dec,
    output logic [ADDR_W-1:0] nxt
);

    localparam int EW = ADDR_W + 1;

    logic [ADDR_W-1:0] msk;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] len_nz;
    logic [ADDR_W-1:0] dmod;
    logic [EW-1:0]     up_raw;
    logic [EW-1:0]     up_off;
    logic [EW-1:0]     dn_off;
    logic [EW-1:0]     new_off;

    // Smear the length's leading one downward to get the offset field mask.
    always_comb begin
        msk = len;
        for (int k = 0; k < ADDR_W; k++) begin
            msk = msk | (msk >> 1);
        end
    end

    // Split the pointer and reduce the displacement below the length once.
    always_comb begin
        base   = ptr & ~msk;
        off    = ptr & msk;
        len_nz = (len == '0) ? ADDR_W'(1) : len;
        dmod   = disp % len_nz;
    end

    // Move the offset within [0, LEN) with one conditional correction each way.
    always_comb begin
        up_raw = {1'b0, off} + {1'b0, dmod};
        up_off = (up_raw >= {1'b0, len}) ? (up_raw - {1'b0, len}) : up_raw;
        dn_off = (off >= dmod) ? ({1'b0, off} - {1'b0, dmod})
                               : ({1'b0, off} + {1'b0, len} - {1'b0, dmod});
        new_off = dec ? dn_off : up_off;
    end

    // Choose the linear result when circular wrap is off.
    always_comb begin
        if (len == '0) begin
            nxt = dec ? (ptr - disp) : (ptr + disp);
        end else begin
            nxt = base | new_off[ADDR_W-1:0];
        end
    end

    AST_CIRC_STAYS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (len != '0 && off < len) |-> ((nxt & msk) < len && (nxt & ~msk) == base)); // R8

endmodule

// File: rtl/agu_revcarry_add.sv
// Adder whose carry runs from the most significant bit toward bit 0.
// Built as an ordinary adder between two bit-order reversals (wiring only).
// Assumes: nothing; purely combinational.
module agu_revcarry_add #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    output logic [ADDR_W-1:0] sum
);

    logic [ADDR_W-1:0] ra;
    logic [ADDR_W-1:0] rb;
    logic [ADDR_W-1:0] rs;

    for (genvar g = 0; g < ADDR_W; g++) begin : g_rev
        assign ra[g]  = a[ADDR_W-1-g];
        assign rb[g]  = b[ADDR_W-1-g];
        assign sum[g] = rs[ADDR_W-1-g];
    end

    // Forward addition in the reversed bit order.
    always_comb begin
        rs = ra + rb;
    end

endmodule

// File: rtl/addr_gen_unit.sv
// Address generator top: selects a pointer and a displacement, forms the
// effective address and the updated pointer for the requested mode, and
// commits the update into the register file at the next edge.
// Assumes: one access and one register write at most per cycle.
module addr_gen_unit
    import agu_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NPTR   = 8,
    parameter int IMM_W  = 8,
    localparam int SEL_W = $clog2(NPTR),
    localparam int WA_W  = $clog2(NPTR + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [3:0]        acc_mode,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic [1:0]        disp_src,
    input  logic [IMM_W-1:0]  disp_imm,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] ptr_next,
    output logic              ptr_we
);

    logic [NPTR-1:0][ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] idx0_q;
    logic [ADDR_W-1:0] idx1_q;
    logic [ADDR_W-1:0] blk_q;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] circ_nxt;
    logic [ADDR_W-1:0] br_nxt;
    logic              upd;
    agu_mode_e         mode;
    agu_disp_e         dsel;

    agu_regfile #(
        .ADDR_W (ADDR_W),
        .NPTR   (NPTR),
        .SEL_W  (SEL_W),
        .WA_W   (WA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .upd_en  (ptr_we),
        .upd_sel (acc_sel),
        .upd_val (ptr_next),
        .ptr_q   (ptr_q),
        .idx0_q  (idx0_q),
        .idx1_q  (idx1_q),
        .blk_q   (blk_q)
    );

    agu_circ_step #(
        .ADDR_W (ADDR_W)
    ) u_circ (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr   (cur),
        .disp  (disp),
        .len   (blk_q),
        .dec   (mode == AM_CIRC_DEC),
        .nxt   (circ_nxt)
    );

    agu_revcarry_add #(
        .ADDR_W (ADDR_W)
    ) u_brev (
        .a   (cur),
        .b   (idx0_q),
        .sum (br_nxt)
    );

    // Decode the raw codes and fetch the selected pointer.
    always_comb begin
        mode = agu_mode_e'(acc_mode);
        dsel = agu_disp_e'(disp_src);
        cur  = ptr_q[acc_sel];
    end

    // Pick the displacement source.
    always_comb begin
        case (dsel)
            DS_IMM:  disp = {{(ADDR_W-IMM_W){1'b0}}, disp_imm};
            DS_IDX0: disp = idx0_q;
            DS_IDX1: disp = idx1_q;
            default: disp = ADDR_W'(1);
        endcase
    end

    // Form the effective address and the pointer update for the mode.
    always_comb begin
        ea       = cur;
        ptr_next = cur;
        upd      = 1'b0;
        case (mode)
            AM_POST_INC: begin ptr_next = cur + disp; upd = 1'b1; end
            AM_POST_DEC: begin ptr_next = cur - disp; upd = 1'b1; end
            AM_PRE_INC:  begin ea = cur + disp; ptr_next = cur + disp; upd = 1'b1; end
            AM_PRE_DEC:  begin ea = cur - disp; ptr_next = cur - disp; upd = 1'b1; end
            AM_OFFSET:   begin ea = cur + disp; end
            AM_CIRC_INC, AM_CIRC_DEC: begin ptr_next = circ_nxt; upd = 1'b1; end
            AM_BITREV:   begin ptr_next = br_nxt; upd = 1'b1; end
            default:     begin end
        endcase
    end

    // Gate the commit with the access strobe.
    always_comb begin
        ptr_we = acc_valid & upd;
    end

    AST_PRE_WRITES_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (mode == AM_PRE_INC || mode == AM_PRE_DEC))
        |-> (ptr_we && ea == ptr_next)); // R6

    AST_OFFSET_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && mode == AM_OFFSET) |-> (!ptr_we && ptr_next == cur)); // R7

endmodule

// File: tb/addr_gen_unit_bench.sv
module addr_gen_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [3:0]  acc_mode = '0;
    logic [2:0]  acc_sel = '0;
    logic [1:0]  disp_src = '0;
    logic [7:0]  disp_imm = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [23:0] ea;
    logic [23:0] ptr_next;
    logic        ptr_we;

    int vec = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [23:0] mp [8];
    logic [23:0] mi0;
    logic [23:0] mi1;
    logic [23:0] mblk;

    always #4 clk = ~clk;

    addr_gen_unit u_addr_gen_unit (
        .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid), .acc_mode (acc_mode),
        .acc_sel (acc_sel), .disp_src (disp_src), .disp_imm (disp_imm),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .ea (ea), .ptr_next (ptr_next), .ptr_we (ptr_we)
    );

    function automatic logic [23:0] rc_add(input logic [23:0] a, input logic [23:0] b);
        logic [23:0] r;
        logic c;
        c = 1'b0;
        for (int i = 23; i >= 0; i--) begin
            r[i] = a[i] ^ b[i] ^ c;
            c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
        end
        return r;
    endfunction

    function automatic logic [23:0] circ_ref(input logic [23:0] p, input logic [23:0] d,
                                             input logic [23:0] len, input bit down);
        longint pw, off, base, l, dd, no;
        if (len == 0) return down ? p - d : p + d;
        l = longint'(len); dd = longint'(d); pw = 1;
        while (pw <= l) pw = pw * 2;
        off = longint'(p) % pw;
        base = longint'(p) - off;
        if (down) no = (off + l - (dd % l)) % l;
        else      no = (off + dd) % l;
        return 24'(base + no);
    endfunction

    function automatic string mode_tag(input int md);
        case (md)
            0: return "R4";
            1, 2: return "R5";
            3, 4: return "R6";
            5: return "R7";
            6, 7: return (mblk == 0) ? "R9" : "R8";
            8: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic fail_line(input string tag, input logic [23:0] got, input logic [23:0] exp);
        bad++;
        $display("FAIL %s: got %h expected %h", tag, got, exp);
    endtask

    // One cycle: drive, compare against the model, then advance the model.
    task automatic step(input bit v, input int md, input int sel, input int src,
                        input int imm, input bit we, input int wa,
                        input logic [23:0] wd, input string tag);
        logic [23:0] p, d, xea, xnx;
        bit xwe;
        @(negedge clk);
        acc_valid = v; acc_mode = 4'(md); acc_sel = 3'(sel); disp_src = 2'(src);
        disp_imm = 8'(imm); wr_en = we; wr_addr = 4'(wa); wr_data = wd;
        #1;
        p = mp[sel];
        case (src)
            0: d = 24'(imm & 255);
            1: d = mi0;
            2: d = mi1;
            default: d = 24'd1;
        endcase
        xea = p; xnx = p; xwe = 1'b0;
        case (md)
            1: begin xnx = p + d; xwe = 1; end
            2: begin xnx = p - d; xwe = 1; end
            3: begin xea = p + d; xnx = p + d; xwe = 1; end
            4: begin xea = p - d; xnx = p - d; xwe = 1; end
            5: xea = p + d;
            6: begin xnx = circ_ref(p, d, mblk, 0); xwe = 1; end
            7: begin xnx = circ_ref(p, d, mblk, 1); xwe = 1; end
            8: begin xnx = rc_add(p, mi0); xwe = 1; end
            default: ;
        endcase
        xwe = xwe & v;
        vec++;
        if (ea !== xea) fail_line({tag, " ea"}, ea, xea);
        else if (ptr_next !== xnx) fail_line({tag, " ptr_next"}, ptr_next, xnx);
        else if (ptr_we !== xwe) fail_line({tag, " ptr_we"}, 24'(ptr_we), 24'(xwe));
        if (xwe) mp[sel] = xnx;
        if (we) begin
            if (wa < 8) mp[wa] = wd;
            else if (wa == 8) mi0 = wd;
            else if (wa == 9) mi1 = wd;
            else if (wa == 10) mblk = wd;
        end
    endtask

    task automatic wr(input int wa, input logic [23:0] wd, input string tag);
        step(0, 0, 0, 0, 0, 1, wa, wd, tag);
    endtask

    task automatic expect_ea(input logic [23:0] exp, input string tag);
        vec++;
        if (ea !== exp) fail_line(tag, ea, exp);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        int seq [8] = '{0, 4, 2, 6, 1, 5, 3, 7};
        for (int k = 0; k < 8; k++) mp[k] = '0;
        mi0 = '0; mi1 = '0; mblk = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through plain and offset accesses.
        for (int s = 0; s < 8; s++) step(1, 0, s, 0, 0, 0, 0, 0, "R1 pointer");
        step(1, 5, 0, 1, 0, 0, 0, 0, "R1 index0");
        step(1, 5, 0, 2, 0, 0, 0, 0, "R1 index1");
        step(1, 6, 1, 3, 0, 0, 0, 0, "R1 block length");

        // R2/R3: load registers, then sweep all modes, sources and pointers.
        for (int s = 0; s < 8; s++) wr(s, 24'($urandom), "R2 load");
        wr(8, 24'($urandom), "R2 idx0");
        wr(9, 24'hFFFFF0, "R2 idx1");
        for (int md = 0; md < 16; md++)
            for (int src = 0; src < 4; src++)
                for (int s = 0; s < 8; s++) begin
                    int k = md * 32 + src * 8 + s;
                    int wa = k % 16;
                    if (wa == 10) wa = 11;
                    step((k % 5) != 0, md, s, src, $urandom % 256, (k % 7) == 0, wa,
                         24'($urandom), {mode_tag(md), " R3"});
                end

        // R2: ignored write codes leave all registers unchanged.
        for (int wa = 11; wa < 16; wa++) wr(wa, 24'hABCDEF, "R2 ignored code");
        for (int s = 0; s < 8; s++) step(1, 0, s, 0, 0, 0, 0, 0, "R2 ignored ptr");
        step(1, 5, 2, 1, 0, 0, 0, 0, "R2 ignored idx0");
        step(1, 5, 2, 2, 0, 0, 0, 0, "R2 ignored idx1");
        step(1, 6, 3, 0, 7, 0, 0, 0, "R2 ignored blk R9");

        // R2: write port beats an update of the same pointer.
        step(1, 1, 3, 3, 0, 1, 3, 24'h000100, "R2 collision");
        step(1, 0, 3, 0, 0, 0, 0, 0, "R2 collision readback");
        expect_ea(24'h000100, "R2 collision value");
        step(1, 1, 4, 3, 0, 1, 5, 24'h000200, "R2 other pointer");
        step(1, 0, 5, 0, 0, 0, 0, 0, "R2 other readback");

        // R8: circular wrap over every start offset of several lengths.
        wr(9, 24'h001235, "R8 idx1");
        for (int L = 1; L <= 12; L++) begin
            wr(10, 24'(L), "R8 blk");
            for (int off = 0; off < L; off++)
                for (int dir = 0; dir < 2; dir++)
                    for (int dk = 0; dk < 7; dk++) begin
                        int dv;
                        case (dk)
                            0: dv = 0; 1: dv = 1; 2: dv = 2; 3: dv = L - 1;
                            4: dv = L; 5: dv = L + 3; default: dv = 200;
                        endcase
                        wr(2, 24'h809900 | 24'(off), "R8 place");
                        step(1, 6 + dir, 2, (dk == 6) ? 2 : 0, dv, 0, 0, 0, "R8 circ");
                        step(1, 0, 2, 0, 0, 0, 0, 0, "R8 readback");
                    end
        end
        wr(10, 24'd4, "R8 example blk");
        wr(6, 24'h809913, "R8 example ptr");
        step(1, 6, 6, 3, 0, 0, 0, 0, "R8 example");
        step(1, 0, 6, 0, 0, 0, 0, 0, "R8 example readback");
        expect_ea(24'h809910, "R8 example wrap");
        step(1, 7, 6, 3, 0, 0, 0, 0, "R8 example down");
        step(1, 0, 6, 0, 0, 0, 0, 0, "R8 example down readback");
        expect_ea(24'h809913, "R8 example wrap down");

        // R9: zero length gives linear stepping.
        wr(10, 24'd0, "R9 blk zero");
        wr(6, 24'hFFFFFE, "R9 ptr");
        step(1, 6, 6, 0, 5, 0, 0, 0, "R9 linear up");
        step(1, 7, 6, 0, 9, 0, 0, 0, "R9 linear down");

        // R10: FFT reorder sequence for eight points, then random pairs.
        wr(8, 24'd4, "R10 idx0");
        wr(1, 24'd0, "R10 ptr");
        for (int k = 0; k < 8; k++) begin
            step(1, 8, 1, k % 4, 0, 0, 0, 0, "R10 sequence");
            expect_ea(24'(seq[k]), "R10 order");
        end
        for (int k = 0; k < 150; k++) begin
            wr(1, 24'($urandom), "R10 ptr");
            wr(8, 24'($urandom), "R10 idx0");
            step(1, 8, 1, k % 4, 0, 0, 0, 0, "R10 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule